// File: doc/BRIEF.md
# Power-Down Entry and Key Wakeup Controller

This block decides when a small processor core enters its RAM-retention power-down state and when it leaves it. The core's decoder hands it one strobe per completed instruction: an arm strobe, a power-off strobe, or neither. Entry needs two steps. An arm instruction must be followed at once by a power-off instruction. A lone power-off, a power-off after some other instruction, or an arm issued while interrupts are enabled does not power the core down.

While powered down, the block watches a group of key inputs. Each key has its own wakeup enable. Enabled keys are combined with a wired-AND, and disabled keys are forced high. A falling edge on the combined line clears the power-down state and gives a one-cycle wakeup pulse. The same edge also sets a sticky status bit. That bit tells firmware that the data pointer and some flags hold undefined values and must be written again. Firmware clears the bit with an acknowledge input.

Top module: `pdn_wake_ctrl`

## Requirements
- R1: A power-off strobe (`instr_valid_i`=1, `pwr_off_i`=1) in the instruction immediately after an arm strobe (`instr_valid_i`=1, `arm_i`=1) sets `pdn_o` at the clock edge that samples the power-off. Cycles with `instr_valid_i`=0 between the two are stalls and do not break the pair.
- R2: A power-off strobe that is not preceded by an arm leaves `pdn_o` low.
- R3: A valid instruction that is neither arm nor power-off, coming between arm and power-off, cancels the arm, so the power-off that follows has no effect.
- R4: An arm strobe is refused while `irq_en_i`=1. A pending arm is dropped in any cycle where `irq_en_i`=1.
- R5: While `pdn_o`=1, a falling edge on the AND of the enabled keys clears `pdn_o` at the next clock edge. At that same edge `wake_o` goes high, and it stays high for exactly one cycle.
- R6: If any enabled key is already low when power-down is entered, the drop of that key is not seen as a wakeup. A wakeup then needs the combined line to rise and fall again.
- R7: A key whose enable bit is 0 is treated as high. It can neither cause nor block a wakeup. With no key enabled, no wakeup occurs.
- R8: `regs_undef_o` is set at the edge that raises `wake_o` and holds until `undef_clr_i`=1 is sampled.
- R9: After reset, `pdn_o`, `wake_o` and `regs_undef_o` are 0 and no arm is pending.
- R10: Arm and power-off strobes are ignored while `pdn_o`=1. An arm issued during power-down does not stay pending after wakeup.
- R11: A key falling edge while `pdn_o`=0 raises neither `wake_o` nor `regs_undef_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_valid_i | input | 1 | An instruction completes this cycle |
| arm_i | input | 1 | Decoded arm instruction |
| pwr_off_i | input | 1 | Decoded power-off instruction |
| irq_en_i | input | 1 | Interrupt master enable status |
| key_i | input | NKEYS | Key input levels |
| key_wake_en_i | input | NKEYS | Per-key wakeup enable |
| undef_clr_i | input | 1 | Firmware acknowledge, clears regs_undef_o |
| pdn_o | output | 1 | Power-down state |
| wake_o | output | 1 | One-cycle wakeup pulse |
| regs_undef_o | output | 1 | Volatile registers are undefined after wakeup |

## Verification
The assertions assume that `arm_i` and `pwr_off_i` are never high together in the same valid instruction. They also assume that keys and enables are synchronous to `clk_i`. The stimulus decodes at most one strobe per instruction and changes every input only at the falling clock edge. The key sweep resets the block between patterns. This is needed because a powered-down core with no enabled key can never wake.

// File: rtl/pdn_pkg.sv
package pdn_pkg;
  typedef enum logic [1:0] {
    INS_NONE  = 2'd0,
    INS_ARM   = 2'd1,
    INS_OFF   = 2'd2,
    INS_OTHER = 2'd3
  } ins_kind_e;
endpackage

// File: rtl/pdn_arm_seq.sv
module pdn_arm_seq
  import pdn_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic instr_valid_i,
  input  logic arm_i,
  input  logic pwr_off_i,
  input  logic irq_en_i,
  input  logic pdn_i,
  output logic armed_o,
  output logic enter_o
);
  ins_kind_e kind;
  logic armed_q, armed_d;

  always_comb begin
    if (!instr_valid_i)  kind = INS_NONE;
    else if (arm_i)      kind = INS_ARM;
    else if (pwr_off_i)  kind = INS_OFF;
    else                 kind = INS_OTHER;
  end

  always_comb begin
    armed_d = armed_q;
    if (pdn_i || irq_en_i) armed_d = 1'b0;
    else begin
      case (kind)
        INS_NONE: armed_d = armed_q;   // stall keeps the pair intact
        INS_ARM:  armed_d = 1'b1;
        default:  armed_d = 1'b0;      // power-off consumes, others cancel
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= armed_d;

  assign enter_o = (kind == INS_OFF) && armed_q && !irq_en_i && !pdn_i;
  assign armed_o = armed_q;

  a_r4_no_arm_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_en_i |=> !armed_q);
  a_r3_other_cancels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && !arm_i) |=> !armed_q);
  a_r10_no_arm_in_pdn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdn_i |=> !armed_q);
endmodule

// File: rtl/pdn_key_edge.sv
module pdn_key_edge #(
  parameter int NKEYS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NKEYS-1:0] key_i,
  input  logic [NKEYS-1:0] key_wake_en_i,
  output logic             fall_o
);
  logic [NKEYS-1:0] masked;
  logic comb, comb_q;

  for (genvar k = 0; k < NKEYS; k++) begin : g_mask
    // disabled key is forced high so it cannot pull the wired-AND
    assign masked[k] = key_i[k] | ~key_wake_en_i[k];
  end

  assign comb = &masked;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) comb_q <= 1'b1;
    else         comb_q <= comb;

  assign fall_o = comb_q & ~comb;

  a_r7_fall_needs_enabled_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> |(key_wake_en_i & ~key_i));
endmodule

// File: rtl/pdn_state.sv
module pdn_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enter_i,
  input  logic fall_i,
  input  logic undef_clr_i,
  output logic pdn_o,
  output logic wake_o,
  output logic regs_undef_o
);
  logic pdn_q, wake_q, undef_q, wake_ev;

  assign wake_ev = pdn_q & fall_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pdn_q   <= 1'b0;
      wake_q  <= 1'b0;
      undef_q <= 1'b0;
    end else begin
      if (enter_i)      pdn_q <= 1'b1;
      else if (wake_ev) pdn_q <= 1'b0;
      wake_q <= wake_ev;
      if (wake_ev)          undef_q <= 1'b1;
      else if (undef_clr_i) undef_q <= 1'b0;
    end
  end

  assign pdn_o        = pdn_q;
  assign wake_o       = wake_q;
  assign regs_undef_o = undef_q;

  a_r5_wake_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_q |=> !wake_q);
  a_r5_exit_by_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pdn_q) |-> wake_q);
  a_r11_no_wake_awake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pdn_q && !wake_q) |=> !wake_q);
endmodule

// File: rtl/pdn_wake_ctrl.sv
module pdn_wake_ctrl #(
  parameter int NKEYS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             instr_valid_i,
  input  logic             arm_i,
  input  logic             pwr_off_i,
  input  logic             irq_en_i,
  input  logic [NKEYS-1:0] key_i,
  input  logic [NKEYS-1:0] key_wake_en_i,
  input  logic             undef_clr_i,
  output logic             pdn_o,
  output logic             wake_o,
  output logic             regs_undef_o
);
  logic armed, enter, fall, pdn;

  pdn_arm_seq u_arm (
    .clk_i, .rst_ni, .instr_valid_i, .arm_i, .pwr_off_i, .irq_en_i,
    .pdn_i(pdn), .armed_o(armed), .enter_o(enter)
  );

  pdn_key_edge #(.NKEYS(NKEYS)) u_key (
    .clk_i, .rst_ni, .key_i, .key_wake_en_i, .fall_o(fall)
  );

  pdn_state u_st (
    .clk_i, .rst_ni, .enter_i(enter), .fall_i(fall), .undef_clr_i,
    .pdn_o(pdn), .wake_o, .regs_undef_o
  );

  assign pdn_o = pdn;

  a_r1_entry_after_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pdn) |-> $past(armed && instr_valid_i && pwr_off_i));
  a_r2_off_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && pwr_off_i && !armed && !pdn) |=> !pdn);
  a_r8_undef_with_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> regs_undef_o);
endmodule

// File: tb/pdn_wake_ctrl_test.sv
module pdn_wake_ctrl_test;
  localparam int N = 3;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic instr_valid = 0, arm = 0, off = 0, irq_en = 0, uclr = 0;
  logic [N-1:0] key = '1, en = '0;
  logic pdn, wake, undef;
  int runs = 0, fails = 0;

  always #2 clk = ~clk;

  pdn_wake_ctrl #(.NKEYS(N)) uut (
    .clk_i(clk), .rst_ni, .instr_valid_i(instr_valid), .arm_i(arm), .pwr_off_i(off),
    .irq_en_i(irq_en), .key_i(key), .key_wake_en_i(en), .undef_clr_i(uclr),
    .pdn_o(pdn), .wake_o(wake), .regs_undef_o(undef)
  );

  task automatic chk(string req, logic act, logic exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // inputs change at negedge, held for one posedge
  task automatic ins(logic v, logic a, logic o);
    instr_valid = v; arm = a; off = o;
    @(negedge clk);
    instr_valid = 0; arm = 0; off = 0;
  endtask

  task automatic do_reset();
    rst_ni = 0; instr_valid = 0; arm = 0; off = 0; irq_en = 0; uclr = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: got hang expected finish");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    key = '1; en = 3'b111;
    do_reset();
    chk("R9 pdn", pdn, 0); chk("R9 wake", wake, 0); chk("R9 undef", undef, 0);
    ins(1, 0, 1);                  // R9: no arm pending after reset
    chk("R9 no pending arm", pdn, 0);

    ins(1, 0, 1); chk("R2 lone off", pdn, 0);
    ins(1, 1, 0); ins(1, 0, 0); ins(1, 0, 1); chk("R3 other cancels", pdn, 0);
    irq_en = 1; ins(1, 1, 0); irq_en = 0; ins(1, 0, 1); chk("R4 arm refused", pdn, 0);
    ins(1, 1, 0); irq_en = 1; ins(0, 0, 0); irq_en = 0; ins(1, 0, 1);
    chk("R4 arm dropped", pdn, 0);
    key = 3'b110; @(negedge clk); chk("R11 fall awake wake", wake, 0);
    chk("R11 fall awake undef", undef, 0);
    key = '1; @(negedge clk);

    ins(1, 1, 0); ins(0, 0, 0); ins(0, 0, 0); ins(1, 0, 1);
    chk("R1 stall keeps pair", pdn, 1);
    ins(1, 1, 0);                  // R10 arm while down
    chk("R10 still down", pdn, 1);
    en = 3'b001; key = 3'b101; @(negedge clk);
    chk("R7 disabled key no wake", wake, 0); chk("R7 still down", pdn, 1);
    key = 3'b100; @(negedge clk);
    chk("R5 wake pulse", wake, 1); chk("R5 pdn cleared", pdn, 0);
    chk("R8 undef set", undef, 1);
    @(negedge clk); chk("R5 pulse one cycle", wake, 0); chk("R8 undef held", undef, 1);
    ins(1, 0, 1); chk("R10 arm not kept", pdn, 0);
    uclr = 1; @(negedge clk); uclr = 0; chk("R8 undef cleared", undef, 0);

    key = 3'b110; en = 3'b011; @(negedge clk);
    ins(1, 1, 0); ins(1, 0, 1); chk("R1 entry", pdn, 1);
    key = 3'b100; @(negedge clk); chk("R6 low key no wake", wake, 0);
    key = 3'b111; @(negedge clk); chk("R6 still down", pdn, 1);
    key = 3'b101; @(negedge clk); chk("R6 wake after rise", wake, 1);

    // sweep: enable mask x starting key level, then drop all keys
    for (int m = 0; m < (1 << N); m++) begin
      for (int s = 0; s < (1 << N); s++) begin
        logic init, expw;
        en = N'(m); key = N'(s);
        do_reset();
        init = &(N'(s) | ~N'(m));
        expw = init && (m != 0);
        ins(1, 1, 0); ins(1, 0, 1);
        chk("R1 sweep entry", pdn, 1);
        key = '0; @(negedge clk);
        chk("R6 R7 sweep wake", wake, expw);
        chk("R5 sweep pdn", pdn, !expw);
      end
    end

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule